// File: doc/BRIEF.md
# NAND Command and Address Front-End

This block is the device side of a small NAND memory with a shared 8-bit bus. Commands, addresses and data all arrive on that one bus. A system clock samples the host strobes: chip select (`ce_n`, active low), command strobe (`cle`), address strobe (`ale`), write strobe (`we_n`) and read strobe (`re_n`). Each strobe passes through a two-flop synchronizer, and the block acts on the synchronized WE rising edge and RE falling edge. From these it decodes commands, gathers the address bytes, fills a 32-byte frame register from data cycles and streams that register back out on RE. It also keeps a status byte and drives a ready output that is low while an operation is busy. Every busy period lasts a parameterised number of clock cycles.

The nonvolatile array is a behavioural RAM of `2**FRM_AW` frames. A frame is selected by the low `FRM_AW` bits of the frame number A18..A5, and a block is 128 consecutive frames. Reads, programs and erases take effect only on the last cycle of their busy window, so a reset during busy leaves the array untouched.

The controller states are as follows.

- `ST_IDLE` is ready and holds nothing pending.
- `ST_ADDR` gathers address bytes.
  - After a read, it goes to `ST_XFER`.
  - After a program setup, it goes to `ST_LOAD`.
  - After an erase setup, it goes to `ST_ERCF`.
  - After an ID command, it goes back to `ST_IDLE`.
- `ST_LOAD` takes data bytes. It goes to `ST_PROG` on a confirm that follows at least one data byte.
- `ST_ERCF` waits for the erase confirm and then goes to `ST_ERASE`.
- `ST_XFER`, `ST_PROG`, `ST_ERASE` and `ST_RESET` are the busy states. Each returns to `ST_IDLE` when its counter expires. Any of the first three goes to `ST_RESET` when the reset command arrives.
- The setup commands 00h, 80h, 60h and 90h move any idle state to `ST_ADDR`.
- The reset command FFh moves any idle state to `ST_RESET`.

Top module: `nand_front_end`

## Requirements
- R1: A bus byte is taken on each synchronized rising edge of `we_n` while `ce_n` is low. With `cle`=1 and `ale`=0 it is a command, with `ale`=1 and `cle`=0 it is an address byte, and with both low it is a data byte. A write cycle with `ce_n` high has no effect.
- R2: The recognised commands are:
  - 00h read
  - 80h program setup, confirmed by 10h
  - 60h erase setup, confirmed by D0h
  - 70h status
  - 90h ID
  - FFh reset

  Any other command byte changes nothing.
- R3: A read is 00h followed by three address bytes. The first byte carries A7..A0, the second A15..A8, and the third A18..A16 in bits 2..0, with bits 7..3 ignored. After the third byte, `rdy` is low for exactly `T_READ` cycles while the frame is fetched. Address bytes beyond the required count are ignored.
- R4: In data output mode, each RE falling edge with `ce_n` low presents the byte at the current column and then advances the column. The first byte comes from column A4..A0. Once column 31 has been output, further reads return FFh.
- R5: The program setup 80h fills the frame register with FFh. It then takes three address bytes as in R3, and data bytes are stored from column A4..A0 upward. A 10h confirm starts a busy window of exactly `T_PROG` cycles only if at least one data byte has been loaded since the setup; otherwise the 10h is ignored.
- R6: Programming ANDs the frame register into the stored frame, so bits can only go from 1 to 0. Each frame accepts at most `MAX_NOP` (default 10) programs between erases. A program beyond that leaves the array unchanged and reports failure.
- R7: An erase is 60h, then two address bytes, then D0h, followed by a busy window of exactly `T_ERASE` cycles. The block is taken from bits 7..4 of the first byte and bits 2..0 of the second byte (A18..A12). Bits A11..A8 are ignored. All 128 frames of the block then read FFh.
- R8: The status byte is:
  - bit 0: result of the last program or erase (1 = fail)
  - bit 6: ready (1) or busy (0)
  - bit 7: `wp_n`
  - bits 5..1: always 0

  Status mode is entered by 70h or by a program or erase confirm. The status byte is shown live on `io_out` until another mode-changing command arrives.
- R9: While `rdy` is low, only 70h and FFh take effect. Other commands, address bytes and data bytes are ignored.
- R10: FFh starts a reset busy window of exactly `T_RST` cycles and selects data output mode. If it arrives during a program or erase, that operation makes no change to the array. FFh during a reset is ignored.
- R11: 90h followed by one address byte enters ID mode. Successive RE reads then return ECh, then A4h, then 00h.
- R12: A program or erase confirmed while `wp_n` is low still runs its busy window. It leaves the array unchanged and sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ce_n | input | 1 | chip select, active low |
| cle | input | 1 | command strobe qualifier |
| ale | input | 1 | address strobe qualifier |
| we_n | input | 1 | write strobe, byte taken on rising edge |
| re_n | input | 1 | read strobe, byte advanced on falling edge |
| wp_n | input | 1 | write protect, active low |
| io_in | input | 8 | bus byte from host |
| io_out | output | 8 | bus byte to host |
| io_oe | output | 1 | output enable for `io_out` |
| rdy | output | 1 | ready (1) / busy (0) |

## Verification
Two interactions can land in one busy window: a status read, and a command that busy mode must reject or obey. The bench confirms a program and then, before `rdy` returns, issues 70h and reads the status byte. It expects 80h, meaning busy with write protect off. It also sends a 00h that must not take effect, so the mode after completion must still be status. In a second case, FFh lands inside a running program. The bench judges this by the reset-length busy tail and by a read-back showing the target frame still erased.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
    localparam int FRAME_BYTES = 32;
    localparam int FRAME_BITS  = FRAME_BYTES * 8;
    localparam int BLK_FRAMES  = 128;

    localparam logic [7:0] CMD_READ   = 8'h00;
    localparam logic [7:0] CMD_PROG   = 8'h80;
    localparam logic [7:0] CMD_PCONF  = 8'h10;
    localparam logic [7:0] CMD_ERASE  = 8'h60;
    localparam logic [7:0] CMD_ECONF  = 8'hD0;
    localparam logic [7:0] CMD_STATUS = 8'h70;
    localparam logic [7:0] CMD_ID     = 8'h90;
    localparam logic [7:0] CMD_RESET  = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_LOAD, ST_ERCF,
        ST_XFER, ST_PROG, ST_ERASE, ST_RESET
    } nfe_state_e;

    typedef enum logic [1:0] {K_READ, K_PROG, K_ERASE, K_ID} nfe_kind_e;

    typedef enum logic [1:0] {OUT_DATA, OUT_STATUS, OUT_ID} nfe_out_e;
endpackage

// File: rtl/nfe_edge_det.sv
module nfe_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic [2:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= 3'b111;
        else        sh <= {sh[1:0], pin};
    end

    assign rise = sh[1] & ~sh[2];
    assign fall = ~sh[1] & sh[2];
endmodule

// File: rtl/nfe_frame_store.sv
module nfe_frame_store
    import nfe_pkg::*;
#(
    parameter int FRM_AW  = 8,
    parameter int MAX_NOP = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  er_en,
    input  logic [FRM_AW-1:0]     idx,
    input  logic [FRM_AW-8:0]     blk,
    input  logic [FRAME_BITS-1:0] wr_data,
    output logic [FRAME_BITS-1:0] rd_data,
    output logic                  nop_full
);
    localparam int DEPTH = 1 << FRM_AW;
    localparam int NW    = $clog2(MAX_NOP + 1);

    logic [FRAME_BITS-1:0] mem [DEPTH];
    logic [NW-1:0]         nop [DEPTH];

    assign rd_data  = mem[idx];
    assign nop_full = (nop[idx] >= NW'(MAX_NOP));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
                nop[i] <= '0;
            end
        end else if (er_en) begin
            for (int j = 0; j < BLK_FRAMES; j++) begin
                mem[{blk, 7'(j)}] <= '1;
                nop[{blk, 7'(j)}] <= '0;
            end
        end else if (wr_en && !nop_full) begin
            mem[idx] <= mem[idx] & wr_data;
            nop[idx] <= nop[idx] + 1'b1;
        end
    end
endmodule

// File: rtl/nand_front_end.sv
module nand_front_end
    import nfe_pkg::*;
#(
    parameter int FRM_AW  = 8,
    parameter int MAX_NOP = 10,
    parameter int T_READ  = 12,
    parameter int T_PROG  = 40,
    parameter int T_ERASE = 60,
    parameter int T_RST   = 10,
    parameter logic [7:0] ID0 = 8'hEC,
    parameter logic [7:0] ID1 = 8'hA4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ce_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we_n,
    input  logic       re_n,
    input  logic       wp_n,
    input  logic [7:0] io_in,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       rdy
);
    localparam int T_MAX0 = (T_READ > T_PROG) ? T_READ : T_PROG;
    localparam int T_MAX1 = (T_ERASE > T_RST) ? T_ERASE : T_RST;
    localparam int T_MAX  = (T_MAX0 > T_MAX1) ? T_MAX0 : T_MAX1;
    localparam int CW     = $clog2(T_MAX + 1);
    localparam int BLK_W  = FRM_AW - 7;

    nfe_state_e state, nxt;
    nfe_kind_e  kind;
    nfe_out_e   out_sel;

    logic [7:0]            a0, a1, a2;
    logic [1:0]            acnt;
    logic [5:0]            col;
    logic [FRAME_BITS-1:0] fr;
    logic                  loaded, prot, fail;
    logic [1:0]            id_idx;
    logic [7:0]            out_q;
    logic [CW-1:0]         cnt;

    logic we_rise, we_fall_unused, re_rise_unused, re_fall;
    logic wr_ev, cmd_ev, addr_ev, data_ev, re_ev, rst_cmd;
    logic busy, addr_last, enter_busy, done;
    logic prog_done, erase_done, xfer_done, arr_wr, arr_er, nop_full;
    logic [FRAME_BITS-1:0] arr_rd;
    logic [FRM_AW-1:0]     frm_idx;
    logic [BLK_W-1:0]      blk_idx;

    nfe_edge_det u_we (.clk(clk), .rst_n(rst_n), .pin(we_n),
                       .rise(we_rise), .fall(we_fall_unused));
    nfe_edge_det u_re (.clk(clk), .rst_n(rst_n), .pin(re_n),
                       .rise(re_rise_unused), .fall(re_fall));

    function automatic logic is_busy(nfe_state_e s);
        return (s == ST_XFER) || (s == ST_PROG) || (s == ST_ERASE) || (s == ST_RESET);
    endfunction

    function automatic logic [CW-1:0] busy_len(nfe_state_e s);
        unique case (s)
            ST_XFER:  return CW'(T_READ - 1);
            ST_PROG:  return CW'(T_PROG - 1);
            ST_ERASE: return CW'(T_ERASE - 1);
            default:  return CW'(T_RST - 1);
        endcase
    endfunction

    assign wr_ev   = we_rise & ~ce_n;
    assign cmd_ev  = wr_ev & cle & ~ale;
    assign addr_ev = wr_ev & ale & ~cle;
    assign data_ev = wr_ev & ~cle & ~ale;
    assign re_ev   = re_fall & ~ce_n;
    assign rst_cmd = cmd_ev && (io_in == CMD_RESET);
    assign busy    = is_busy(state);

    always_comb begin
        unique case (kind)
            K_READ, K_PROG: addr_last = (acnt == 2'd2);
            K_ERASE:        addr_last = (acnt == 2'd1);
            K_ID:           addr_last = (acnt == 2'd0);
        endcase
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_XFER, ST_PROG, ST_ERASE: begin
                if (rst_cmd)        nxt = ST_RESET;
                else if (cnt == '0) nxt = ST_IDLE;
            end
            ST_RESET: begin
                if (cnt == '0) nxt = ST_IDLE;
            end
            ST_IDLE, ST_ADDR, ST_LOAD, ST_ERCF: begin
                if (cmd_ev) begin
                    case (io_in)
                        CMD_READ, CMD_PROG, CMD_ERASE, CMD_ID: nxt = ST_ADDR;
                        CMD_RESET: nxt = ST_RESET;
                        CMD_PCONF: if (state == ST_LOAD && loaded) nxt = ST_PROG;
                        CMD_ECONF: if (state == ST_ERCF) nxt = ST_ERASE;
                        default: ;
                    endcase
                end else if (addr_ev && state == ST_ADDR && addr_last) begin
                    unique case (kind)
                        K_READ:  nxt = ST_XFER;
                        K_PROG:  nxt = ST_LOAD;
                        K_ERASE: nxt = ST_ERCF;
                        K_ID:    nxt = ST_IDLE;
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign enter_busy = is_busy(nxt) && (nxt != state);
    assign done       = busy && (state != ST_RESET) && (cnt == '0) && !rst_cmd;
    assign prog_done  = done && (state == ST_PROG);
    assign erase_done = done && (state == ST_ERASE);
    assign xfer_done  = done && (state == ST_XFER);
    assign arr_wr     = prog_done && !prot;
    assign arr_er     = erase_done && !prot;

    // frame number A18..A5, block A18..A12 (only low bits reach storage)
    assign frm_idx = FRM_AW'({a2[2:0], a1, a0[7:5]});
    assign blk_idx = BLK_W'({a2[2:0], a1[7:4]});

    nfe_frame_store #(.FRM_AW(FRM_AW), .MAX_NOP(MAX_NOP)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(arr_wr), .er_en(arr_er),
        .idx(frm_idx), .blk(blk_idx), .wr_data(fr),
        .rd_data(arr_rd), .nop_full(nop_full)
    );

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind    <= K_READ;
            out_sel <= OUT_DATA;
            a0      <= '0;
            a1      <= '0;
            a2      <= '0;
            acnt    <= '0;
            col     <= '0;
            fr      <= '1;
            loaded  <= 1'b0;
            prot    <= 1'b0;
            fail    <= 1'b0;
            id_idx  <= '0;
            out_q   <= '0;
            cnt     <= '0;
        end else begin
            if (enter_busy)            cnt <= busy_len(nxt);
            else if (busy && cnt != 0) cnt <= cnt - 1'b1;

            if (!busy && cmd_ev) begin
                case (io_in)
                    CMD_READ:   begin kind <= K_READ;  acnt <= '0; out_sel <= OUT_DATA; end
                    CMD_PROG:   begin kind <= K_PROG;  acnt <= '0; fr <= '1; loaded <= 1'b0; end
                    CMD_ERASE:  begin kind <= K_ERASE; acnt <= '0; end
                    CMD_ID:     begin kind <= K_ID;    acnt <= '0; end
                    CMD_STATUS: out_sel <= OUT_STATUS;
                    CMD_RESET:  out_sel <= OUT_DATA;
                    CMD_PCONF:  if (state == ST_LOAD && loaded) begin
                                    out_sel <= OUT_STATUS;
                                    prot    <= ~wp_n;
                                end
                    CMD_ECONF:  if (state == ST_ERCF) begin
                                    out_sel <= OUT_STATUS;
                                    prot    <= ~wp_n;
                                end
                    default: ;
                endcase
            end
            if (busy && cmd_ev) begin
                if (io_in == CMD_STATUS) out_sel <= OUT_STATUS;
                else if (io_in == CMD_RESET && state != ST_RESET) out_sel <= OUT_DATA;
            end

            if (addr_ev && state == ST_ADDR) begin
                acnt <= acnt + 1'b1;
                if (kind == K_ERASE) begin
                    if (acnt == 2'd0) a1 <= io_in;
                    else              a2 <= io_in;
                end else begin
                    unique case (acnt)
                        2'd0:    a0 <= io_in;
                        2'd1:    a1 <= io_in;
                        default: a2 <= io_in;
                    endcase
                end
                if (addr_last && kind == K_PROG) col <= {1'b0, a0[4:0]};
                if (addr_last && kind == K_ID) begin
                    out_sel <= OUT_ID;
                    id_idx  <= '0;
                end
            end

            if (data_ev && state == ST_LOAD && col != 6'd32) begin
                fr[{col[4:0], 3'b000} +: 8] <= io_in;
                col    <= col + 1'b1;
                loaded <= 1'b1;
            end

            if (xfer_done) begin
                fr  <= arr_rd;
                col <= {1'b0, a0[4:0]};
            end
            if (prog_done)  fail <= prot | nop_full;
            if (erase_done) fail <= prot;

            if (re_ev) begin
                unique case (out_sel)
                    OUT_DATA: if (!busy) begin
                        out_q <= (col == 6'd32) ? 8'hFF : fr[{col[4:0], 3'b000} +: 8];
                        if (col != 6'd32) col <= col + 1'b1;
                    end
                    OUT_ID: begin
                        out_q <= (id_idx == 2'd0) ? ID0 : (id_idx == 2'd1) ? ID1 : 8'h00;
                        if (id_idx != 2'd2) id_idx <= id_idx + 1'b1;
                    end
                    OUT_STATUS: ;
                    default: ;
                endcase
            end
        end
    end

    assign rdy    = ~busy;
    assign io_oe  = ~ce_n & ~re_n;
    assign io_out = (out_sel == OUT_STATUS) ? {wp_n, ~busy, 5'b00000, fail} : out_q;
endmodule

// File: rtl/nfe_checker.sv
module nfe_checker
    import nfe_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rdy,
    input logic                  wr_ev,
    input logic                  arr_wr,
    input logic [5:0]            col,
    input nfe_state_e            state,
    input nfe_out_e              out_sel,
    input logic [7:0]            io_out,
    input logic [FRAME_BITS-1:0] fr
);
    a_r1_busy_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy) |-> $past(wr_ev));

    a_r4_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
        col <= 6'd32);

    a_r5_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr |=> $rose(rdy));

    a_r8_status_live: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == OUT_STATUS) |-> (io_out[6] == rdy) && (io_out[5:1] == 5'd0));

    a_r9_frame_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG || state == ST_ERASE) |=> $stable(fr));
endmodule

bind nand_front_end nfe_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rdy(rdy), .wr_ev(wr_ev), .arr_wr(arr_wr),
    .col(col), .state(state), .out_sel(out_sel), .io_out(io_out), .fr(fr)
);

// File: tb/nand_front_end_test.sv
module nand_front_end_test;
    localparam int CLK_PERIOD = 10;
    localparam int T_READ  = 12;
    localparam int T_PROG  = 40;
    localparam int T_ERASE = 60;
    localparam int T_RST   = 10;
    localparam int WD_CYC  = 150000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ce_n = 1'b0, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
    logic [7:0] io_in = '0, io_out;
    logic io_oe, rdy;

    int total = 0, bad = 0, busy_cnt = 0;
    bit finished = 0;

    logic [7:0] mm [int];
    int         nop_m [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_front_end #(.T_READ(T_READ), .T_PROG(T_PROG), .T_ERASE(T_ERASE), .T_RST(T_RST)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
        .re_n(re_n), .wp_n(wp_n), .io_in(io_in), .io_out(io_out), .io_oe(io_oe), .rdy(rdy)
    );

    // per-clock comparison of the busy count and of the output enable
    always @(negedge clk) begin
        if (rst_n && !rdy) busy_cnt++;
        if (rst_n && io_oe !== (!ce_n && !re_n)) begin
            total++; bad++;
            $display("FAIL R4 io_oe act=%0b exp=%0b", io_oe, !ce_n && !re_n);
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic wcyc(logic c, logic a, logic [7:0] b);
        @(negedge clk);
        cle = c; ale = a; io_in = b; we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (5) @(negedge clk);
        cle = 1'b0; ale = 1'b0;
    endtask

    task automatic wr_cmd(logic [7:0] b);  wcyc(1'b1, 1'b0, b); endtask
    task automatic wr_addr(logic [7:0] b); wcyc(1'b0, 1'b1, b); endtask
    task automatic wr_data(logic [7:0] b); wcyc(1'b0, 1'b0, b); endtask

    task automatic rd_byte(output logic [7:0] b);
        @(negedge clk);
        re_n = 1'b0;
        repeat (5) @(negedge clk);
        b = io_out;
        re_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_rdy();
        while (!rdy) @(negedge clk);
    endtask

    function automatic logic [7:0] mget(int f, int c);
        return mm.exists(f * 32 + c) ? mm[f * 32 + c] : 8'hFF;
    endfunction

    task automatic send_addr3(int f, int c);
        wr_addr({f[2:0], c[4:0]});
        wr_addr(f[10:3]);
        wr_addr({5'b11111, f[13:11]});   // R3: upper five bits don't care
    endtask

    task automatic prog(int f, int c, logic [7:0] d[$], bit extra_addr);
        logic [7:0] st;
        bit fl;
        int n;
        wr_cmd(8'h80);
        send_addr3(f, c);
        if (extra_addr) wr_addr(8'h1F);  // R3: surplus address byte
        foreach (d[i]) wr_data(d[i]);
        n = nop_m.exists(f) ? nop_m[f] : 0;
        fl = !wp_n || (n >= 10);
        busy_cnt = 0;
        wr_cmd(8'h10);
        wait_rdy();
        chk("R5", "program busy length", busy_cnt, T_PROG);
        if (!fl) begin
            foreach (d[i]) if (c + i < 32) mm[f * 32 + c + i] = mget(f, c + i) & d[i];
            nop_m[f] = n + 1;
        end
        rd_byte(st);
        chk(fl ? "R6" : "R8", "status after program", st, {wp_n, 1'b1, 5'b0, fl});
    endtask

    task automatic readf(int f, int c, int n);
        logic [7:0] b;
        wr_cmd(8'h00);
        busy_cnt = 0;
        send_addr3(f, c);
        wait_rdy();
        chk("R3", "read busy length", busy_cnt, T_READ);
        for (int i = 0; i < n; i++) begin
            rd_byte(b);
            chk("R4", $sformatf("frame %0d col %0d", f, c + i), b,
                (c + i < 32) ? mget(f, c + i) : 8'hFF);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
        finish_up();
    end

    initial begin
        logic [7:0] b;
        logic [7:0] q[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "reset rdy", rdy, 1);
        chk("R4", "reset io_oe", io_oe, 0);

        // R11 ID bytes
        wr_cmd(8'h90); wr_addr(8'h00);
        rd_byte(b); chk("R11", "id byte 0", b, 8'hEC);
        rd_byte(b); chk("R11", "id byte 1", b, 8'hA4);
        rd_byte(b); chk("R11", "id byte 2", b, 8'h00);

        // R8 status idle, with and without write protect
        wr_cmd(8'h70);
        rd_byte(b); chk("R8", "idle status", b, 8'hC0);
        wp_n = 1'b0; repeat (2) @(negedge clk);
        rd_byte(b); chk("R12", "protected idle status", b, 8'h40);
        wp_n = 1'b1;

        // R2 unknown command ignored: status mode survives
        wr_cmd(8'h55);
        rd_byte(b); chk("R2", "status after unknown cmd", b, 8'hC0);

        // R5/R9 program with status read and a rejected read during busy
        wr_cmd(8'h80); send_addr3(5, 2);
        q = '{8'h11, 8'h22, 8'h33, 8'h44};
        foreach (q[i]) wr_data(q[i]);
        busy_cnt = 0;
        wr_cmd(8'h10);
        wr_cmd(8'h70);
        rd_byte(b); chk("R9", "status while program busy", b, 8'h80);
        wr_cmd(8'h00);                      // R9: must be ignored
        wait_rdy();
        chk("R5", "program busy length", busy_cnt, T_PROG);
        foreach (q[i]) mm[5 * 32 + 2 + i] = q[i];
        nop_m[5] = 1;
        rd_byte(b); chk("R9", "still status after busy", b, 8'hC0);

        readf(5, 0, 33);
        readf(5, 30, 3);

        // R6 AND merge
        prog(5, 3, '{8'h0F, 8'hF0}, 0);
        readf(5, 2, 4);

        // R5 confirm with no data ignored; R1 CE-high data ignored; R3 extra addr
        wr_cmd(8'h80); send_addr3(100, 4);
        busy_cnt = 0;
        wr_cmd(8'h10);
        repeat (5) @(negedge clk);
        chk("R5", "empty confirm stays ready", busy_cnt, 0);
        ce_n = 1'b1; wr_data(8'h00); ce_n = 1'b0;   // R1: ignored
        wr_addr(8'h1F);                           // R3: ignored
        wr_data(8'hA5);
        busy_cnt = 0;
        wr_cmd(8'h10);
        wait_rdy();
        chk("R5", "late confirm busy", busy_cnt, T_PROG);
        mm[100 * 32 + 4] = 8'hA5; nop_m[100] = 1;
        rd_byte(b);
        readf(100, 3, 3);

        // R7 erase block 0 with junk in A11..A8
        wr_cmd(8'h60);
        wr_addr(8'h0A);
        wr_addr(8'hA8);
        busy_cnt = 0;
        wr_cmd(8'hD0);
        wait_rdy();
        chk("R7", "erase busy length", busy_cnt, T_ERASE);
        rd_byte(b); chk("R7", "erase status", b, 8'hC0);
        for (int f = 0; f < 128; f++) begin
            for (int c = 0; c < 32; c++) mm.delete(f * 32 + c);
            nop_m.delete(f);
        end
        readf(5, 2, 2);
        readf(100, 4, 1);

        // R6 partial-program limit
        for (int k = 0; k < 11; k++) prog(9, k, '{8'(8'hF0 ^ k)}, (k == 0));
        readf(9, 9, 3);

        // R12 write protect
        wp_n = 1'b0;
        prog(20, 0, '{8'h00}, 0);
        wp_n = 1'b1;
        readf(20, 0, 1);

        // R10 reset from idle, then reset abort of a program
        busy_cnt = 0;
        wr_cmd(8'hFF);
        wait_rdy();
        chk("R10", "reset busy length", busy_cnt, T_RST);
        wr_cmd(8'h80); send_addr3(30, 0); wr_data(8'h00);
        busy_cnt = 0;
        wr_cmd(8'h10);
        wr_cmd(8'hFF);
        wait_rdy();
        chk("R10", "abort shorter than program", int'(busy_cnt < T_PROG + T_RST && busy_cnt > T_RST), 1);
        readf(30, 0, 2);

        finish_up();
    end
endmodule